// File: doc/BRIEF.md
# Prescaled Event-Driven Target Timer

An up-counter of `CNT_W` bits (16 by default) that advances once per tick of a power-of-two prescaler. The prescaler is fed either by every cycle of the block clock or by edges of one line chosen from a synchronous event bus, with the active edge selectable. The counter runs against a target value in one of two modes. In one-shot mode it stops at the target and drops its own enable. In continuous mode it wraps to zero and starts the next period. Each completion is flagged by a single-cycle event output.

Software drives the block through four word registers on a simple write strobe / combinational read bus: a configuration word, a control word holding the enable, the target, and a read-only view of the live count. Writing the enable to one always restarts a run from a clean state. The target may be changed in the middle of a run.

Top module: `evt_target_timer`

## Requirements
- R1: After reset all four registers read zero and `ev_o` is low.
- R2: Byte offsets decode on `bus_addr[3:2]`: 0x0 configuration, 0x4 control, 0x8 target, 0xC count. Configuration bit 0 is the mode (1 continuous), bit 1 the source (1 event bus), bits 7:4 the exponent, bits 13:8 the line select and bit 14 the polarity (1 falling edge). Control bit 0 is the enable, and target bits 15:0 hold the target. All other bits read zero. Writes to the count register have no effect.
- R3: A control write with bit 0 set clears the count and the prescaler on that clock edge, even while a run is already in progress.
- R4: With the clock as source and exponent p, the count advances once every 2^p cycles after the enable edge.
- R5: In one-shot mode with target T≥1, the count stops at T and the enable bit reads zero. `ev_o` is high for exactly the one cycle in which the final count first appears.
- R6: In one-shot mode a target of 0 behaves like a target of 1: the count stops at 1 and a single event pulse is produced.
- R7: In continuous mode with target T≥2, the count runs 0..T−1 and then returns to 0. `ev_o` pulses for one cycle each time the count returns to 0, but not at the enable edge.
- R8: In continuous mode with target 0 or 1, the count stays at 0. With exponent 0, `ev_o` is high in every cycle from one cycle after the enable edge onward.
- R9: With the event bus as source, only edges of the selected line of the chosen polarity advance the prescaler. Edges on other lines and edges of the other polarity do nothing.
- R10: The select code `SELF_CODE` (0x36 by default) never produces a tick, whatever happens on that bus line.
- R11: A target written during a run is used in the comparison from the next tick onward.
- R12: Writing the enable to zero freezes the count and suppresses further events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Byte offset of the register being accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| ev_bus | input | LINES | Synchronous event lines |
| ev_o | output | 1 | Completion / wrap event pulse |

## Verification
The bench sweeps the target across 0..5 and the exponent across the small values for both modes. This exposes any design that compares against T instead of T−1 in continuous mode, or against T−1 instead of T in one-shot mode. Such a design would show a period one tick off or an extra count. A design that pulses at the enable edge, or that fails to treat a zero target as one, changes the event timing that the bench predicts cycle by cycle. Restarting a run mid-period catches a prescaler that is not cleared, because the first increment would then come too early. Rewriting the target mid-run, and toggling the wrong line, the wrong polarity or the self-referencing select code, catches a stale comparison and a sloppy edge decoder.

// File: rtl/ett_pkg.sv
package ett_pkg;
   // Register index taken from byte-offset bits [3:2]
   typedef enum logic [1:0] {
      REG_CFG = 2'd0,
      REG_CTL = 2'd1,
      REG_TGT = 2'd2,
      REG_CNT = 2'd3
   } ett_reg_e;

   // Configuration word field positions
   localparam int CFG_CONT_BIT = 0;
   localparam int CFG_SRC_BIT  = 1;
   localparam int CFG_PRE_LSB  = 4;
   localparam int CFG_SEL_LSB  = 8;
   localparam int CFG_POL_BIT  = 14;
   localparam int CTL_EN_BIT   = 0;
endpackage

// File: rtl/ett_regs.sv
module ett_regs
   import ett_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int SEL_W  = 6,
   parameter int PRE_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              hw_stop,
   input  logic [CNT_W-1:0]  cnt,
   output logic              cfg_cont,
   output logic              cfg_src,
   output logic [PRE_W-1:0]  cfg_pre,
   output logic [SEL_W-1:0]  cfg_sel,
   output logic              cfg_fall,
   output logic [CNT_W-1:0]  target,
   output logic              en_q,
   output logic              ctl_wr,
   output logic              start
);
   ett_reg_e idx;
   logic     cfg_wr, tgt_wr;
   logic     unused_ok;

   assign idx    = ett_reg_e'(addr[3:2]);
   assign cfg_wr = wr_en && (idx == REG_CFG);
   assign ctl_wr = wr_en && (idx == REG_CTL);
   assign tgt_wr = wr_en && (idx == REG_TGT);
   assign start  = ctl_wr && wdata[CTL_EN_BIT];
   assign unused_ok = ^{wdata, addr[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_cont <= 1'b0;
         cfg_src  <= 1'b0;
         cfg_pre  <= '0;
         cfg_sel  <= '0;
         cfg_fall <= 1'b0;
         target   <= '0;
         en_q     <= 1'b0;
      end else begin
         if (cfg_wr) begin
            cfg_cont <= wdata[CFG_CONT_BIT];
            cfg_src  <= wdata[CFG_SRC_BIT];
            cfg_pre  <= wdata[CFG_PRE_LSB +: PRE_W];
            cfg_sel  <= wdata[CFG_SEL_LSB +: SEL_W];
            cfg_fall <= wdata[CFG_POL_BIT];
         end
         if (tgt_wr) target <= wdata[CNT_W-1:0];
         // software write wins over the one-shot hardware clear
         if (ctl_wr)       en_q <= wdata[CTL_EN_BIT];
         else if (hw_stop) en_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (idx)
         REG_CFG: begin
            rdata[CFG_CONT_BIT]             = cfg_cont;
            rdata[CFG_SRC_BIT]              = cfg_src;
            rdata[CFG_PRE_LSB +: PRE_W]     = cfg_pre;
            rdata[CFG_SEL_LSB +: SEL_W]     = cfg_sel;
            rdata[CFG_POL_BIT]              = cfg_fall;
         end
         REG_CTL: rdata[CTL_EN_BIT]   = en_q;
         REG_TGT: rdata[CNT_W-1:0]    = target;
         REG_CNT: rdata[CNT_W-1:0]    = cnt;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/ett_tick_gen.sv
module ett_tick_gen #(
   parameter int LINES     = 64,
   parameter int SEL_W     = 6,
   parameter int PRE_W     = 4,
   parameter int SELF_CODE = 54
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] ev_bus,
   input  logic             src_ev,
   input  logic [SEL_W-1:0] sel,
   input  logic             fall,
   input  logic [PRE_W-1:0] pre,
   input  logic             en,
   input  logic             start,
   output logic             raw_tick,
   output logic             tick
);
   localparam int DIV_W = (1 << PRE_W) - 1;

   logic [LINES-1:0] bus_m;
   logic             cur, prev_q, edge_hit;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W:0]   lim_w;
   logic             div_full;

   // the timer's own event line is blanked so it reads as "no event"
   generate
      if (SELF_CODE >= 0 && SELF_CODE < LINES) begin : g_mask
         always_comb begin
            bus_m            = ev_bus;
            bus_m[SELF_CODE] = 1'b0;
         end
      end else begin : g_nomask
         assign bus_m = ev_bus;
      end
   endgenerate

   assign cur      = bus_m[sel];
   assign edge_hit = fall ? (prev_q & ~cur) : (cur & ~prev_q);
   assign raw_tick = en & (src_ev ? edge_hit : 1'b1);

   assign lim_w    = ((DIV_W+1)'(1) << pre) - (DIV_W+1)'(1);
   assign div_full = ({1'b0, div_q} >= lim_w);
   assign tick     = raw_tick & div_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         div_q  <= '0;
      end else begin
         prev_q <= cur;
         if (start)         div_q <= '0;
         else if (raw_tick) div_q <= div_full ? '0 : div_q + 1'b1;
      end
   end
endmodule

// File: rtl/ett_counter.sv
module ett_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic             cont,
   input  logic [CNT_W-1:0] target,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ev_o,
   output logic             hw_stop
);
   logic [CNT_W:0] inc;
   logic           reached, wrap;

   assign inc     = {1'b0, cnt_q} + 1'b1;
   // one-shot: a zero target is met by the first increment
   assign reached = (inc >= {1'b0, target});
   // continuous: targets below two pin the count at zero
   assign wrap    = (target < CNT_W'(2)) || (cnt_q >= target - CNT_W'(1));
   assign hw_stop = tick && !cont && reached;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ev_o  <= 1'b0;
      end else if (start) begin
         cnt_q <= '0;
         ev_o  <= 1'b0;
      end else if (tick) begin
         if (cont) begin
            cnt_q <= wrap ? '0 : inc[CNT_W-1:0];
            ev_o  <= wrap;
         end else begin
            cnt_q <= inc[CNT_W-1:0];
            ev_o  <= reached;
         end
      end else begin
         ev_o <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_target_timer.sv
module evt_target_timer #(
   parameter int CNT_W     = 16,
   parameter int LINES     = 64,
   parameter int PRE_W     = 4,
   parameter int DATA_W    = 32,
   parameter int SELF_CODE = 54
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [3:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [LINES-1:0]  ev_bus,
   output logic              ev_o
);
   localparam int SEL_W = $clog2(LINES);

   generate
      if (SEL_W > 6 || (1 << SEL_W) != LINES)
         $error("LINES must be a power of two no larger than 64");
      if (PRE_W < 1 || PRE_W > 4)
         $error("PRE_W must lie in 1..4");
      if (CNT_W < 2 || CNT_W > DATA_W || DATA_W < 15)
         $error("CNT_W must lie in 2..DATA_W and DATA_W must be at least 15");
   endgenerate

   logic             cfg_cont, cfg_src, cfg_fall;
   logic [PRE_W-1:0] cfg_pre;
   logic [SEL_W-1:0] cfg_sel;
   logic [CNT_W-1:0] target, cnt_q;
   logic             en_q, ctl_wr, start, hw_stop, raw_tick, tick;

   ett_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .hw_stop(hw_stop), .cnt(cnt_q),
      .cfg_cont(cfg_cont), .cfg_src(cfg_src), .cfg_pre(cfg_pre),
      .cfg_sel(cfg_sel), .cfg_fall(cfg_fall), .target(target),
      .en_q(en_q), .ctl_wr(ctl_wr), .start(start)
   );

   ett_tick_gen #(.LINES(LINES), .SEL_W(SEL_W), .PRE_W(PRE_W), .SELF_CODE(SELF_CODE)) u_tick (
      .clk(clk), .rst_n(rst_n), .ev_bus(ev_bus), .src_ev(cfg_src),
      .sel(cfg_sel), .fall(cfg_fall), .pre(cfg_pre), .en(en_q),
      .start(start), .raw_tick(raw_tick), .tick(tick)
   );

   ett_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
      .cont(cfg_cont), .target(target), .cnt_q(cnt_q),
      .ev_o(ev_o), .hw_stop(hw_stop)
   );
endmodule

// File: rtl/ett_chk.sv
module ett_chk #(
   parameter int CNT_W     = 16,
   parameter int SEL_W     = 6,
   parameter int SELF_CODE = 54
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_q,
   input logic             tick,
   input logic             raw_tick,
   input logic             start,
   input logic             ctl_wr,
   input logic [CNT_W-1:0] cnt_q,
   input logic             ev_o,
   input logic             cont,
   input logic [CNT_W-1:0] target,
   input logic             src_ev,
   input logic [SEL_W-1:0] sel
);
   // R5
   oneshot_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en_q) && !$past(ctl_wr)) |-> ev_o);

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !start) |=> $stable(cnt_q));

   // R8
   small_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && (target < CNT_W'(2)) && tick && !start) |=> (cnt_q == '0));

   // R10
   self_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ev && (sel == SEL_W'(SELF_CODE))) |-> !raw_tick);

   // R4
   tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> en_q);

   // R3
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == '0) && !ev_o);
endmodule

bind evt_target_timer ett_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SELF_CODE(SELF_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_q(en_q), .tick(tick), .raw_tick(raw_tick),
   .start(start), .ctl_wr(ctl_wr), .cnt_q(cnt_q), .ev_o(ev_o),
   .cont(cfg_cont), .target(target), .src_ev(cfg_src), .sel(cfg_sel)
);

// File: tb/tb_evt_target_timer.sv
`timescale 1ns/1ps
module tb_evt_target_timer;
   localparam int SELF = 54;
   localparam logic [3:0] A_CFG = 4'h0, A_CTL = 4'h4, A_TGT = 4'h8, A_CNT = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] ev_bus = '0;
   logic        ev_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   evt_target_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_bus(ev_bus), .ev_o(ev_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic pulse(input int line, output logic [31:0] mid, output logic ev_mid);
      ev_bus[line] = 1'b1;
      step();
      rd(A_CNT, mid);
      ev_mid = ev_o;
      ev_bus[line] = 1'b0;
      step();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        em;

      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(A_CFG, d); chk("R1 cfg", d, 0);
      rd(A_CTL, d); chk("R1 ctl", d, 0);
      rd(A_TGT, d); chk("R1 tgt", d, 0);
      rd(A_CNT, d); chk("R1 cnt", d, 0);
      chk("R1 ev", {31'b0, ev_o}, 0);

      // R2 readback, reserved bits, read-only count
      wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, d); chk("R2 cfg fields", d, 32'h0000_7FF3);
      wr(A_TGT, 32'hFFFF_ABCD); rd(A_TGT, d); chk("R2 tgt field", d, 32'h0000_ABCD);
      wr(A_CNT, 32'h0000_1234); rd(A_CNT, d); chk("R2 cnt read-only", d, 0);
      wr(A_CFG, 32'h0);         rd(A_CFG, d); chk("R2 cfg clear", d, 0);

      // R4 R5 R6 one-shot sweep over exponent and target
      for (int p = 0; p < 3; p++) begin
         for (int t = 0; t < 6; t++) begin
            int fin;
            int stop;
            fin  = (t == 0) ? 1 : t;
            stop = fin << p;
            wr(A_TGT, t);
            wr(A_CFG, p << 4);
            wr(A_CTL, 1);
            rd(A_CNT, d); chk("R3 count after enable", d, 0);
            for (int c = 1; c <= stop + 3; c++) begin
               int e;
               step();
               e = ((c >> p) < fin) ? (c >> p) : fin;
               rd(A_CNT, d);
               chk((t == 0) ? "R6 one-shot zero-target count" : "R4 R5 one-shot count", d, e);
               chk((t == 0) ? "R6 one-shot event" : "R5 one-shot event", {31'b0, ev_o}, (c == stop) ? 1 : 0);
               if (c == stop) begin
                  rd(A_CTL, d); chk("R5 enable cleared", d, 0);
               end
            end
         end
      end

      // R7 R8 continuous sweep
      for (int p = 0; p < 2; p++) begin
         for (int t = 0; t < 6; t++) begin
            int per;
            per = (t < 2) ? 2 : t;
            wr(A_CTL, 0);
            wr(A_TGT, t);
            wr(A_CFG, 1 | (p << 4));
            wr(A_CTL, 1);
            chk("R7 no event at enable", {31'b0, ev_o}, 0);
            for (int c = 1; c <= 3 * (per << p); c++) begin
               int k;
               int ec;
               int ee;
               step();
               k  = c >> p;
               ec = (t < 2) ? 0 : (k % t);
               ee = ((c % (1 << p)) == 0 && k >= 1 && (t < 2 || (k % t) == 0)) ? 1 : 0;
               rd(A_CNT, d);
               chk((t < 2) ? "R8 small-target count" : "R7 continuous count", d, ec);
               chk((t < 2) ? "R8 small-target event" : "R7 continuous event", {31'b0, ev_o}, ee);
            end
            // R12 disable freezes count
            wr(A_CTL, 0);
            begin
               logic [31:0] held;
               rd(A_CNT, held);
               step();
               step();
               rd(A_CNT, d); chk("R12 frozen count", d, held);
               chk("R12 no event when off", {31'b0, ev_o}, 0);
            end
         end
      end

      // R3 restart mid-run, count and prescaler cleared
      wr(A_TGT, 10);
      wr(A_CFG, 1);
      wr(A_CTL, 1);
      repeat (5) step();
      rd(A_CNT, d); chk("R3 pre-restart count", d, 5);
      wr(A_CTL, 1);
      rd(A_CNT, d); chk("R3 restart clears count", d, 0);
      step();
      rd(A_CNT, d); chk("R3 count after restart", d, 1);
      wr(A_CTL, 0);
      wr(A_CFG, 1 | (2 << 4));
      wr(A_CTL, 1);
      repeat (6) step();
      rd(A_CNT, d); chk("R4 prescaled count", d, 1);
      wr(A_CTL, 1);
      repeat (3) step();
      rd(A_CNT, d); chk("R3 prescaler cleared", d, 0);
      step();
      rd(A_CNT, d); chk("R3 first prescaled tick", d, 1);

      // R11 target rewrite during a one-shot run
      wr(A_CTL, 0);
      wr(A_TGT, 100);
      wr(A_CFG, 0);
      wr(A_CTL, 1);
      repeat (5) step();
      rd(A_CNT, d); chk("R11 count before rewrite", d, 5);
      wr(A_TGT, 3);
      rd(A_CNT, d); chk("R11 count at rewrite", d, 6);
      chk("R11 no event at rewrite", {31'b0, ev_o}, 0);
      step();
      rd(A_CNT, d); chk("R11 stops on new target", d, 7);
      chk("R11 event on new target", {31'b0, ev_o}, 1);
      rd(A_CTL, d); chk("R11 enable cleared", d, 0);
      step();
      rd(A_CNT, d); chk("R11 stays stopped", d, 7);
      chk("R11 event single cycle", {31'b0, ev_o}, 0);

      // R9 rising edges of line 5
      wr(A_TGT, 3);
      wr(A_CFG, (1 << 1) | (5 << 8));
      wr(A_CTL, 1);
      step();
      pulse(6, d, em);
      rd(A_CNT, d); chk("R9 other line ignored", d, 0);
      for (int k = 1; k <= 3; k++) begin
         pulse(5, d, em);
         chk("R9 rising counted on rise", d, k);
         chk("R9 event on final rise", {31'b0, em}, (k == 3) ? 1 : 0);
         rd(A_CNT, d); chk("R9 fall ignored when rising", d, k);
      end
      rd(A_CTL, d); chk("R9 one-shot stop on events", d, 0);

      // R9 falling edges of line 5
      wr(A_CFG, (1 << 1) | (5 << 8) | (1 << 14));
      wr(A_CTL, 1);
      for (int k = 1; k <= 3; k++) begin
         pulse(5, d, em);
         chk("R9 rise ignored when falling", d, k - 1);
         rd(A_CNT, d); chk("R9 falling counted", d, k);
         chk("R9 event on final fall", {31'b0, ev_o}, (k == 3) ? 1 : 0);
      end

      // R4 R9 prescaled event source
      wr(A_TGT, 2);
      wr(A_CFG, (1 << 1) | (5 << 8) | (1 << 4));
      wr(A_CTL, 1);
      for (int k = 1; k <= 4; k++) begin
         pulse(5, d, em);
         rd(A_CNT, d); chk("R4 R9 prescaled edges", d, k >> 1);
      end

      // R10 self code never ticks
      wr(A_TGT, 3);
      wr(A_CFG, (1 << 1) | (SELF << 8));
      wr(A_CTL, 1);
      for (int k = 1; k <= 3; k++) begin
         pulse(SELF, d, em);
         chk("R10 self code mid", d, 0);
      end
      rd(A_CNT, d); chk("R10 self code count", d, 0);
      rd(A_CTL, d); chk("R10 still enabled", d, 1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule